// File: doc/BRIEF.md
# Data TLB Lookup and Fault Classifier

This block is a fully associative translation buffer on the data side of a processor pipeline. A request carries a virtual address, a context number, a user-mode flag and an access kind: ordinary load, store or nonfaulting load. The block searches every stored entry in parallel. It then returns read and write permissions, or a trap code together with a fault status word.

The fault status word records what the access was (a store, or a nonfaulting load) and which data-access conditions were hit. Nonfaulting loads are checked differently from other accesses. Such a load faults on pages that have side effects, and it is the only kind of access allowed on no-fault-only pages. Several fault-type flags can be raised together. Any data-access fault takes precedence over a write-protection fault.

Entries are loaded through a fill port that takes an index, a virtual page tag, a context and a 64-bit translation word. Miss handling by a table walker, context registers and trap dispatch are left to the surrounding logic.

Top module: `dtlb_lookup`

## Requirements
- R1: After reset, `rsp_valid` is low and every entry is invalid, so any lookup returns the miss trap until entries are filled.
- R2: A lookup is accepted in the cycle `req_valid` is high. Its result appears on the outputs, with `rsp_valid` high for exactly one cycle, one clock later. `rsp_valid` stays low after a cycle without a request.
- R3: An entry matches when bit 63 of its translation word (valid) is set and its stored tag equals `req_vaddr[VA_W-1:PAGE_SHIFT]`. Its context must also equal `req_ctx`, unless bit 0 of the word (global) is set. With no match the trap code is 3 (miss), both permissions are low and fault-type flags 2..4 are clear.
- R4: When several entries match, the entry with the lowest index decides the result.
- R5: A user-mode access (`req_user`=1) to an entry whose bit 2 (privileged) is set gives trap code 1 (data access) and sets status bit 2.
- R6: A nonfaulting load to an entry whose bit 3 (side effect) is set gives trap code 1 and sets status bit 3. Ordinary loads to such an entry are not faulted by this bit.
- R7: Any access other than a nonfaulting load to an entry whose bit 60 (no-fault-only) is set gives trap code 1 and sets status bit 4. A nonfaulting load to such an entry is allowed.
- R8: When several data-access conditions hold at once, every matching fault-type flag is set in the same status word.
- R9: Trap code 2 (write protection) is raised only for a store to an entry with bit 1 (writable) clear when no data-access fault applies. A data-access fault on a store suppresses it.
- R10: `req_kind` is encoded as 0 load, 1 store, 2 nonfaulting load and 3 treated as a load. Status bit 0 is set for every store and status bit 1 for every nonfaulting load, whatever the trap.
- R11: With no fault the trap code is 0, `rsp_read` is high, and `rsp_write` equals bit 1 of the entry. On any trap both permissions are low.
- R12: A fill (`fill_en`) replaces the entry at `fill_idx` at the clock edge. A lookup in the same cycle still sees the old entry, and the next lookup sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_ctx | input | CTX_W | Context number of the access |
| req_user | input | 1 | 1 for a user-mode access |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 nonfaulting load, 3 as load |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | IDX_W | Entry index to write |
| fill_tag | input | TAG_W | Virtual page tag of the new entry |
| fill_ctx | input | CTX_W | Context of the new entry |
| fill_data | input | 64 | Translation word of the new entry |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_trap | output | 2 | 0 none, 1 data access, 2 write protection, 3 miss |
| rsp_read | output | 1 | Read permission granted |
| rsp_write | output | 1 | Write permission granted |
| rsp_fstat | output | 5 | Status: 0 write, 1 nonfaulting, 2 privilege, 3 nonfaulting-to-side-effect, 4 no-fault-only |

## Verification
The bench fills entries that each carry one attribute, or a mix of attributes. It then replays a vector table against them.

Several corner cases are covered:
- A store to a privileged, no-fault-only, read-only page from user mode must report two flags and a data-access trap. A design that let write protection win, or kept only the first flag found, reports trap 2 or loses a status bit.
- Nonfaulting loads go to side-effect pages and to no-fault-only pages. These catch a design that swaps the two checks or applies them to every access kind.
- Two entries match the same address, the earlier one read-only. A design that picks the highest index grants a write instead of trapping.
- A global entry is looked up under a foreign context. A design that ignores the global bit misses instead of granting access.
- A fill and a lookup to the same entry in the same cycle catch a design that bypasses new fill data into the search.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

   // translation word attribute positions (decoded by the classifier)
   localparam int unsigned TW_VALID  = 63;
   localparam int unsigned TW_NFONLY = 60;
   localparam int unsigned TW_USED   = 41;
   localparam int unsigned TW_LOCK   = 6;
   localparam int unsigned TW_SIDEFX = 3;
   localparam int unsigned TW_PRIV   = 2;
   localparam int unsigned TW_WRITE  = 1;
   localparam int unsigned TW_GLOBAL = 0;

   // fault status word layout
   localparam int unsigned FS_W      = 5;
   localparam int unsigned FS_STORE  = 0;
   localparam int unsigned FS_NFLD   = 1;
   localparam int unsigned FS_PRIV   = 2;
   localparam int unsigned FS_NFSE   = 3;
   localparam int unsigned FS_NFONLY = 4;

   typedef enum logic [1:0] {
      ACC_LOAD   = 2'd0,
      ACC_STORE  = 2'd1,
      ACC_NFLOAD = 2'd2,
      ACC_RSVD   = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      TRAP_NONE  = 2'd0,
      TRAP_DACC  = 2'd1,
      TRAP_DPROT = 2'd2,
      TRAP_DMISS = 2'd3
   } trap_e;

endpackage

// File: rtl/dtlb_store.sv
module dtlb_store #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned TAG_W   = 51,
   parameter int unsigned CTX_W   = 13,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [CTX_W-1:0] wr_ctx,
   input  logic [63:0]      wr_word,
   output logic [TAG_W-1:0] ent_tag  [ENTRIES],
   output logic [CTX_W-1:0] ent_ctx  [ENTRIES],
   output logic [63:0]      ent_word [ENTRIES]
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_tag[e]  <= '0;
            ent_ctx[e]  <= '0;
            ent_word[e] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            ent_tag[e]  <= wr_tag;
            ent_ctx[e]  <= wr_ctx;
            ent_word[e] <= wr_word;
         end
      end
   end

endmodule

// File: rtl/dtlb_match.sv
module dtlb_match
   import dtlb_pkg::*;
#(
   parameter int unsigned ENTRIES   = 64,
   parameter int unsigned TAG_W     = 51,
   parameter int unsigned CTX_W     = 13,
   parameter bit          GLOBAL_EN = 1'b1,
   localparam int unsigned IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [TAG_W-1:0] q_tag,
   input  logic [CTX_W-1:0] q_ctx,
   input  logic [TAG_W-1:0] ent_tag  [ENTRIES],
   input  logic [CTX_W-1:0] ent_ctx  [ENTRIES],
   input  logic [63:0]      ent_word [ENTRIES],
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);

   logic [ENTRIES-1:0] ent_hit;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic ctx_ok;
      if (GLOBAL_EN) begin : g_glb
         assign ctx_ok = ent_word[e][TW_GLOBAL] || (ent_ctx[e] == q_ctx);
      end else begin : g_noglb
         assign ctx_ok = (ent_ctx[e] == q_ctx);
      end
      assign ent_hit[e] = ent_word[e][TW_VALID] && ctx_ok && (ent_tag[e] == q_tag);
   end

   // lowest index wins: scan downward so the last assignment is the lowest hit
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (ent_hit[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = |ent_hit;

endmodule

// File: rtl/dtlb_classify.sv
module dtlb_classify
   import dtlb_pkg::*;
(
   input  logic            hit,
   input  logic [63:0]     word,
   input  logic            user,
   input  logic [1:0]      kind,
   output logic [1:0]      trap,
   output logic            can_rd,
   output logic            can_wr,
   output logic [FS_W-1:0] fstat
);

   logic is_st, is_nf, dacc;

   assign is_st = (kind == ACC_STORE);
   assign is_nf = (kind == ACC_NFLOAD);

   always_comb begin
      fstat            = '0;
      fstat[FS_STORE]  = is_st;
      fstat[FS_NFLD]   = is_nf;
      if (hit) begin
         fstat[FS_PRIV] = word[TW_PRIV] && user;
         if (is_nf) fstat[FS_NFSE]   = word[TW_SIDEFX];
         else       fstat[FS_NFONLY] = word[TW_NFONLY];
      end
   end

   assign dacc = fstat[FS_PRIV] || fstat[FS_NFSE] || fstat[FS_NFONLY];

   always_comb begin
      trap   = TRAP_NONE;
      can_rd = 1'b0;
      can_wr = 1'b0;
      if (!hit)                                 trap = TRAP_DMISS;
      else if (dacc)                            trap = TRAP_DACC;
      else if (is_st && !word[TW_WRITE])        trap = TRAP_DPROT;
      else begin
         can_rd = 1'b1;
         can_wr = word[TW_WRITE];
      end
   end

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
   import dtlb_pkg::*;
#(
   parameter int unsigned ENTRIES    = 64,
   parameter int unsigned VA_W       = 64,
   parameter int unsigned PAGE_SHIFT = 13,
   parameter int unsigned CTX_W      = 13,
   parameter bit          GLOBAL_EN  = 1'b1,
   localparam int unsigned TAG_W     = VA_W - PAGE_SHIFT,
   localparam int unsigned IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [CTX_W-1:0] req_ctx,
   input  logic             req_user,
   input  logic [1:0]       req_kind,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [CTX_W-1:0] fill_ctx,
   input  logic [63:0]      fill_data,
   output logic             rsp_valid,
   output logic [1:0]       rsp_trap,
   output logic             rsp_read,
   output logic             rsp_write,
   output logic [FS_W-1:0]  rsp_fstat
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("dtlb_lookup: ENTRIES must be at least 2");
   end
   if (PAGE_SHIFT >= VA_W) begin : g_bad_page
      $error("dtlb_lookup: PAGE_SHIFT must be below VA_W");
   end
   if (CTX_W < 1) begin : g_bad_ctx
      $error("dtlb_lookup: CTX_W must be positive");
   end

   logic [TAG_W-1:0] e_tag  [ENTRIES];
   logic [CTX_W-1:0] e_ctx  [ENTRIES];
   logic [63:0]      e_word [ENTRIES];
   logic             m_hit;
   logic [IDX_W-1:0] m_idx;
   logic [1:0]       c_trap;
   logic             c_rd, c_wr;
   logic [FS_W-1:0]  c_fstat;

   dtlb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fill_en),
      .wr_idx   (fill_idx),
      .wr_tag   (fill_tag),
      .wr_ctx   (fill_ctx),
      .wr_word  (fill_data),
      .ent_tag  (e_tag),
      .ent_ctx  (e_ctx),
      .ent_word (e_word)
   );

   dtlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W),
                .GLOBAL_EN(GLOBAL_EN)) u_match (
      .q_tag    (req_vaddr[VA_W-1:PAGE_SHIFT]),
      .q_ctx    (req_ctx),
      .ent_tag  (e_tag),
      .ent_ctx  (e_ctx),
      .ent_word (e_word),
      .hit      (m_hit),
      .hit_idx  (m_idx)
   );

   dtlb_classify u_class (
      .hit    (m_hit),
      .word   (e_word[m_idx]),
      .user   (req_user),
      .kind   (req_kind),
      .trap   (c_trap),
      .can_rd (c_rd),
      .can_wr (c_wr),
      .fstat  (c_fstat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_trap  <= TRAP_NONE;
         rsp_read  <= 1'b0;
         rsp_write <= 1'b0;
         rsp_fstat <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_trap  <= c_trap;
            rsp_read  <= c_rd;
            rsp_write <= c_wr;
            rsp_fstat <= c_fstat;
         end
      end
   end

   // R2: one response pulse per request, one cycle later
   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R10: store flag follows the request kind
   assert_store_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == ACC_STORE) |=> rsp_fstat[FS_STORE]);
   assert_nf_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == ACC_NFLOAD) |=> rsp_fstat[FS_NFLD]);
   // R3: a miss grants nothing and raises no fault-type flag
   assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap == TRAP_DMISS) |->
         (!rsp_read && !rsp_write && rsp_fstat[FS_NFONLY:FS_PRIV] == '0));
   // R9: write protection only on a clean store
   assert_dprot_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap == TRAP_DPROT) |->
         (rsp_fstat[FS_STORE] && rsp_fstat[FS_NFONLY:FS_PRIV] == '0));
   // R8: a data-access trap always carries at least one fault-type flag
   assert_dacc_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap == TRAP_DACC) |-> (rsp_fstat[FS_NFONLY:FS_PRIV] != '0));
   // R11: no trap means read granted; a trap means no permission
   assert_ok_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap == TRAP_NONE) |-> rsp_read);
   assert_trap_denies_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap != TRAP_NONE) |-> (!rsp_read && !rsp_write));

endmodule

// File: tb/tb_dtlb_lookup.sv
module tb_dtlb_lookup;
   localparam int unsigned VA_W = 64, PS = 13, CTX_W = 13, ENT = 64;
   localparam int unsigned TAG_W = VA_W - PS;

   localparam logic [63:0] B_V   = 64'h1 << 63;
   localparam logic [63:0] B_NFO = 64'h1 << 60;
   localparam logic [63:0] B_E   = 64'h1 << 3;
   localparam logic [63:0] B_P   = 64'h1 << 2;
   localparam logic [63:0] B_W   = 64'h1 << 1;
   localparam logic [63:0] B_G   = 64'h1;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic             req_valid = 1'b0, req_user = 1'b0;
   logic [VA_W-1:0]  req_vaddr = '0;
   logic [CTX_W-1:0] req_ctx = '0;
   logic [1:0]       req_kind = '0;
   logic             fill_en = 1'b0;
   logic [5:0]       fill_idx = '0;
   logic [TAG_W-1:0] fill_tag = '0;
   logic [CTX_W-1:0] fill_ctx = '0;
   logic [63:0]      fill_data = '0;
   logic             rsp_valid, rsp_read, rsp_write;
   logic [1:0]       rsp_trap;
   logic [4:0]       rsp_fstat;

   dtlb_lookup dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_ctx(req_ctx), .req_user(req_user), .req_kind(req_kind),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
      .fill_ctx(fill_ctx), .fill_data(fill_data), .rsp_valid(rsp_valid),
      .rsp_trap(rsp_trap), .rsp_read(rsp_read), .rsp_write(rsp_write),
      .rsp_fstat(rsp_fstat));

   int n_chk = 0, n_bad = 0;

   typedef struct packed {
      logic [15:0] tag; logic [12:0] ctx; logic user; logic [1:0] kind;
      logic [1:0] trap; logic rd; logic wr; logic [4:0] fs; logic [3:0] rq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{16'h10, 13'd5, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 5'h00, 4'd11}, // R11
      '{16'h10, 13'd5, 1'b1, 2'd1, 2'd0, 1'b1, 1'b1, 5'h01, 4'd10}, // R10
      '{16'h10, 13'd6, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 5'h00, 4'd3},  // R3 ctx
      '{16'h11, 13'd5, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 5'h04, 4'd5},  // R5
      '{16'h11, 13'd5, 1'b0, 2'd1, 2'd0, 1'b1, 1'b1, 5'h01, 4'd5},  // R5
      '{16'h12, 13'd5, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 5'h0A, 4'd6},  // R6
      '{16'h12, 13'd5, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 5'h00, 4'd6},  // R6
      '{16'h13, 13'd5, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 5'h10, 4'd7},  // R7
      '{16'h13, 13'd5, 1'b0, 2'd2, 2'd0, 1'b1, 1'b1, 5'h02, 4'd7},  // R7
      '{16'h13, 13'd5, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 5'h10, 4'd10}, // R10 kind 3
      '{16'h14, 13'd5, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 5'h15, 4'd9},  // R9 R8
      '{16'h14, 13'd5, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 5'h06, 4'd8},  // R8
      '{16'h15, 13'd2, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 5'h00, 4'd3},  // R3 global
      '{16'h16, 13'd5, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 5'h01, 4'd9},  // R9
      '{16'h16, 13'd5, 1'b0, 2'd2, 2'd0, 1'b1, 1'b0, 5'h02, 4'd11}, // R11
      '{16'h20, 13'd5, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 5'h01, 4'd4},  // R4
      '{16'h18, 13'd5, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 5'h00, 4'd3}   // R3 invalid
   };

   task automatic chk(input string rq, input string what, input logic [15:0] got,
                      input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
      end
   endtask

   task automatic fill(input int idx, input int tag, input int ctx, input logic [63:0] d);
      @(negedge clk);
      fill_en = 1'b1; fill_idx = 6'(idx); fill_tag = TAG_W'(tag);
      fill_ctx = CTX_W'(ctx); fill_data = d;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   // issue at a negedge, result sampled at the following negedge
   task automatic look(input int tag, input int ctx, input logic u, input logic [1:0] k);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = (VA_W'(tag) << PS) | VA_W'(12'h3a8);
      req_ctx = CTX_W'(ctx); req_user = u; req_kind = k;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string rq, input logic [1:0] tr, input logic rd,
                             input logic wr, input logic [4:0] fs);
      chk(rq, "valid", 16'(rsp_valid), 16'd1);
      chk(rq, "trap",  16'(rsp_trap), 16'(tr));
      chk(rq, "read",  16'(rsp_read), 16'(rd));
      chk(rq, "write", 16'(rsp_write), 16'(wr));
      chk(rq, "fstat", 16'(rsp_fstat), 16'(fs));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "valid after reset", 16'(rsp_valid), 16'd0);
      rst_n = 1'b1;
      // R1: empty after reset, so a lookup misses
      look(16'h10, 5, 1'b0, 2'd0);
      expect_rsp("R1", 2'd3, 1'b0, 1'b0, 5'h00);
      @(negedge clk);
      chk("R2", "pulse ends", 16'(rsp_valid), 16'd0);

      fill(0,  16'h10, 5, B_V | B_W);
      fill(1,  16'h11, 5, B_V | B_P | B_W);
      fill(2,  16'h12, 5, B_V | B_E);
      fill(3,  16'h13, 5, B_V | B_NFO | B_W);
      fill(4,  16'h14, 5, B_V | B_P | B_NFO);
      fill(5,  16'h15, 9, B_V | B_G | B_W);
      fill(6,  16'h16, 5, B_V);
      fill(7,  16'h20, 5, B_V);
      fill(8,  16'h20, 5, B_V | B_W);
      fill(10, 16'h18, 5, B_W);

      for (int i = 0; i < NV; i++) begin
         look(int'(VECS[i].tag), int'(VECS[i].ctx), VECS[i].user, VECS[i].kind);
         expect_rsp($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].trap,
                    VECS[i].rd, VECS[i].wr, VECS[i].fs);
      end

      // R12: fill and lookup together see the old entry, then the new one
      @(negedge clk);
      fill_en = 1'b1; fill_idx = 6'd6; fill_tag = TAG_W'(16'h16);
      fill_ctx = CTX_W'(5); fill_data = B_V | B_W;
      req_valid = 1'b1; req_vaddr = VA_W'(16'h16) << PS; req_ctx = CTX_W'(5);
      req_user = 1'b0; req_kind = 2'd1;
      @(negedge clk);
      fill_en = 1'b0; req_valid = 1'b0;
      expect_rsp("R12 same cycle", 2'd2, 1'b0, 1'b0, 5'h01);
      look(16'h16, 5, 1'b0, 2'd1);
      expect_rsp("R12 after fill", 2'd0, 1'b1, 1'b1, 5'h01);

      // R12 and R4: overwrite entry 7 to clear it, entry 8 now answers
      fill(7, 16'h20, 5, 64'h0);
      look(16'h20, 5, 1'b0, 2'd1);
      expect_rsp("R4 next match", 2'd0, 1'b1, 1'b1, 5'h01);

      // R2: back-to-back requests give back-to-back pulses
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = VA_W'(16'h10) << PS; req_ctx = CTX_W'(5); req_kind = 2'd0;
      @(negedge clk);
      req_vaddr = VA_W'(16'h11) << PS; req_user = 1'b1;
      expect_rsp("R2 first", 2'd0, 1'b1, 1'b1, 5'h00);
      @(negedge clk);
      req_valid = 1'b0; req_user = 1'b0;
      expect_rsp("R2 second", 2'd1, 1'b0, 1'b0, 5'h04);
      @(negedge clk);
      chk("R2", "idle no pulse", 16'(rsp_valid), 16'd0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule